// File: doc/BRIEF.md
# Line Activity Power Mode Controller

This block is the digital control for a multi-channel serial line interface. Comparators outside the block report, one flag per receive channel, whether a line carries no signal. From these flags and three control pins (a forced-online pin, an active-low shutdown pin and a receiver-disable pin), the block decides when the supply generator and the line drivers are powered. It also drives a registered STATUS output and the output enables of the receiver outputs.

In automatic mode the block drops into standby once every line has been quiet for a set number of cycles. It wakes again when any line shows activity. After a wake, the supply generator runs for a settling interval before the drivers are enabled. STATUS rises after a short confirmation delay once activity appears, and falls after a longer delay once all lines go quiet.

The shutdown pin overrides everything else. The forced-online pin keeps the drivers powered whatever the lines do. Receiver outputs keep working in every power mode, and one non-inverting monitor output can never be disabled. Every delay is a parameter counted in clock cycles.

Top module: `line_power_ctrl`

## Requirements
- R1: While `shutdown_n_i` is low, `pump_en_o`, `status_o` and every `tx_oe_o` bit are low one clock edge later, whatever `online_i` and the lines do.
- R2: With `shutdown_n_i` and `online_i` both high, the block never enters standby, even if every line stays idle. `status_o` still falls when all lines are idle.
- R3: With `shutdown_n_i` high and `online_i` low, standby (`pump_en_o` low) is entered only after all synchronised idle flags have been 1 for STANDBY_CYC consecutive cycles. `pump_en_o` falls STANDBY_CYC+3 edges after the raw flags all go to 1. A quiet gap of STANDBY_CYC-1 cycles does not cause standby, and a single active line keeps the block awake.
- R4: From standby, a line going active raises `pump_en_o` 3 edges later. A rise of `online_i` raises it 1 edge later.
- R5: `status_o` rises STS_RISE_CYC+3 edges after a raw flag goes to 0. Directly after shutdown ends with a line already active, it rises STS_RISE_CYC+1 edges later.
- R6: `status_o` falls STS_FALL_CYC+3 edges after all raw flags go to 1.
- R7: All `tx_oe_o` bits rise SETTLE_CYC edges after `pump_en_o` rises, and never in a cycle whose previous cycle had the supply off.
- R8: Pulling `shutdown_n_i` low during the settling interval cancels the wake, and the drivers stay disabled.
- R9: `rx_out_o` is the bitwise inverse of `rx_line_i` in every power mode. `rx_oe_o` is all ones when `rx_disable_i` is 0 and all zeros when it is 1. Both are combinational.
- R10: `mon_o` equals `rx_line_i[MON_IDX]` (not inverted) in every mode, including shutdown and receiver disable.
- R11: `tx_out_o` is the bitwise inverse of `tx_data_i`. When the drivers are disabled, all `tx_oe_o` bits are 0 (outputs in high impedance).
- R12: Driving `online_i` and `shutdown_n_i` with one signal makes it a plain power pin: 0 turns the supply off after 1 edge, and 1 turns it on after 1 edge with idle lines.
- R13: During reset, `pump_en_o`, `status_o` and `tx_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_idle_i | input | N_RX | Per-line idle flag from the comparators, 1 = no signal (asynchronous) |
| rx_line_i | input | N_RX | Received line levels after the comparators |
| tx_data_i | input | N_TX | Logic-level data for the line drivers |
| online_i | input | 1 | Forced-online pin, synchronous |
| shutdown_n_i | input | 1 | Active-low shutdown pin, synchronous |
| rx_disable_i | input | 1 | Receiver output disable, active high |
| pump_en_o | output | 1 | Supply generator enable |
| tx_oe_o | output | N_TX | Driver output enables |
| tx_out_o | output | N_TX | Inverted driver data |
| status_o | output | 1 | Line activity status |
| rx_out_o | output | N_RX | Inverted receiver outputs |
| rx_oe_o | output | N_RX | Receiver output enables |
| mon_o | output | 1 | Always-driven non-inverting monitor output |

## Verification
An idle-flag change takes three edges to reach the counters: two synchroniser flops, then the counter register. A STATUS change, a standby entry or a wake therefore appears that many edges, plus the delay parameter, after the bench drives it. Control-pin changes act after one edge, driver enables follow the supply by SETTLE_CYC edges, and the receiver, monitor and driver data paths are combinational. The bench records each expected value with the cycle it is due, counted from the drive point. A monitor compares it at the falling clock edge of exactly that cycle, and for the timeout edges it also checks the cycle just before.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    PWR_OFF    = 2'd0,
    PWR_SETTLE = 2'd1,
    PWR_ON     = 2'd2
  } pwr_state_e;

  // saturating run-length step: clears when run is low, stops at lim
  function automatic int unsigned sat_step(input int unsigned cur,
                                           input int unsigned lim,
                                           input logic run);
    if (!run) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

  // bits needed to hold 0..lim
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/lpm_idle_sync.sv
module lpm_idle_sync #(
  parameter int unsigned N_RX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_RX-1:0] idle_raw_i,
  output logic            all_idle_o
);
  logic [N_RX-1:0] meta_q, sync_q;

  for (genvar g = 0; g < N_RX; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b1;
        sync_q[g] <= 1'b1;
      end else begin
        meta_q[g] <= idle_raw_i[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign all_idle_o = &sync_q;
endmodule

// File: rtl/lpm_activity_timer.sv
module lpm_activity_timer #(
  parameter int unsigned STANDBY_CYC  = 5000,
  parameter int unsigned STS_RISE_CYC = 25,
  parameter int unsigned STS_FALL_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic all_idle_i,
  input  logic shdn_n_i,
  output logic idle_done_o,
  output logic status_o
);
  import lpm_pkg::*;
  localparam int unsigned IW = cnt_width(STANDBY_CYC);
  localparam int unsigned AW = cnt_width(STS_RISE_CYC);

  logic [IW-1:0] idle_cnt_q;
  logic [AW-1:0] act_cnt_q;
  logic          status_q, status_d;
  logic          act_done, fall_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt_q <= '0;
      act_cnt_q  <= '0;
      status_q   <= 1'b0;
    end else begin
      idle_cnt_q <= IW'(sat_step(32'(idle_cnt_q), STANDBY_CYC, shdn_n_i & all_idle_i));
      act_cnt_q  <= AW'(sat_step(32'(act_cnt_q), STS_RISE_CYC, shdn_n_i & ~all_idle_i));
      status_q   <= status_d;
    end
  end

  assign act_done    = (act_cnt_q == AW'(STS_RISE_CYC));
  assign fall_done   = (idle_cnt_q >= IW'(STS_FALL_CYC));
  assign idle_done_o = (idle_cnt_q == IW'(STANDBY_CYC));

  always_comb begin
    if (!shdn_n_i)     status_d = 1'b0;
    else if (status_q) status_d = ~fall_done;
    else               status_d = act_done;
  end

  assign status_o = status_q;

  // R5: a rise only follows a full confirmation run of activity
  p_status_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(act_done));
  // R6: a fall only follows a full quiet run, or shutdown
  p_status_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q) |-> ($past(fall_done) || !$past(shdn_n_i)));
  // R1: shutdown clears status
  p_status_shdn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_i |=> !status_q);
endmodule

// File: rtl/lpm_power_fsm.sv
module lpm_power_fsm #(
  parameter int unsigned SETTLE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n_i,
  input  logic online_i,
  input  logic activity_i,
  input  logic idle_done_i,
  output logic pump_on_o,
  output logic drv_on_o
);
  import lpm_pkg::*;
  localparam int unsigned SW = cnt_width(SETTLE_CYC);

  pwr_state_e    state_q, state_d;
  logic [SW-1:0] settle_q, settle_d;
  logic          settle_done, standby_req, wake_req;

  assign settle_done = (settle_q == SW'(SETTLE_CYC - 1));
  assign standby_req = ~online_i & idle_done_i;
  assign wake_req    = online_i | activity_i;

  always_comb begin
    state_d  = state_q;
    settle_d = '0;
    if (!shdn_n_i) begin
      state_d = PWR_OFF;
    end else begin
      case (state_q)
        PWR_OFF:    if (wake_req) state_d = PWR_SETTLE;
        PWR_SETTLE: begin
          settle_d = settle_q + 1'b1;
          if (standby_req)      state_d = PWR_OFF;
          else if (settle_done) state_d = PWR_ON;
        end
        PWR_ON:     if (standby_req) state_d = PWR_OFF;
        default:    state_d = PWR_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PWR_OFF;
      settle_q <= '0;
    end else begin
      state_q  <= state_d;
      settle_q <= settle_d;
    end
  end

  assign pump_on_o = (state_q != PWR_OFF);
  assign drv_on_o  = (state_q == PWR_ON);

  // R1: shutdown forces the off state
  p_shdn_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_i |=> (state_q == PWR_OFF));
  // R2: forced online never drops the supply
  p_forced_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_n_i && online_i && pump_on_o) |=> pump_on_o);
  // R3: supply only drops on timeout in auto mode or on shutdown
  p_standby_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pump_on_o) |-> (!$past(shdn_n_i) || ($past(idle_done_i) && !$past(online_i))));
  // R4: a wake request out of standby starts settling
  p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PWR_OFF && shdn_n_i && wake_req) |=> (state_q == PWR_SETTLE));
  // R8: shutdown during settling cancels the wake
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PWR_SETTLE && !shdn_n_i) |=> !drv_on_o);
endmodule

// File: rtl/lpm_io_gate.sv
module lpm_io_gate #(
  parameter int unsigned N_RX    = 5,
  parameter int unsigned N_TX    = 3,
  parameter int unsigned MON_IDX = 1
) (
  input  logic [N_RX-1:0] rx_line_i,
  input  logic            rx_disable_i,
  input  logic [N_TX-1:0] tx_data_i,
  input  logic            drv_on_i,
  output logic [N_RX-1:0] rx_out_o,
  output logic [N_RX-1:0] rx_oe_o,
  output logic            mon_o,
  output logic [N_TX-1:0] tx_out_o,
  output logic [N_TX-1:0] tx_oe_o
);
  for (genvar r = 0; r < N_RX; r++) begin : g_rx
    assign rx_out_o[r] = ~rx_line_i[r];
    assign rx_oe_o[r]  = ~rx_disable_i;
  end

  for (genvar t = 0; t < N_TX; t++) begin : g_tx
    assign tx_out_o[t] = ~tx_data_i[t];
    assign tx_oe_o[t]  = drv_on_i;
  end

  assign mon_o = rx_line_i[MON_IDX];
endmodule

// File: rtl/line_power_ctrl.sv
module line_power_ctrl #(
  parameter int unsigned N_RX         = 5,
  parameter int unsigned N_TX         = 3,
  parameter int unsigned MON_IDX      = 1,
  parameter int unsigned STANDBY_CYC  = 5000,
  parameter int unsigned STS_RISE_CYC = 25,
  parameter int unsigned STS_FALL_CYC = 1000,
  parameter int unsigned SETTLE_CYC   = 10000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_RX-1:0] line_idle_i,
  input  logic [N_RX-1:0] rx_line_i,
  input  logic [N_TX-1:0] tx_data_i,
  input  logic            online_i,
  input  logic            shutdown_n_i,
  input  logic            rx_disable_i,
  output logic            pump_en_o,
  output logic [N_TX-1:0] tx_oe_o,
  output logic [N_TX-1:0] tx_out_o,
  output logic            status_o,
  output logic [N_RX-1:0] rx_out_o,
  output logic [N_RX-1:0] rx_oe_o,
  output logic            mon_o
);
  // named internal events
  logic all_idle;
  logic idle_done;
  logic drv_on;

  lpm_idle_sync #(.N_RX(N_RX)) u_sync (
    .clk(clk), .rst_n(rst_n), .idle_raw_i(line_idle_i), .all_idle_o(all_idle));

  lpm_activity_timer #(
    .STANDBY_CYC(STANDBY_CYC), .STS_RISE_CYC(STS_RISE_CYC), .STS_FALL_CYC(STS_FALL_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .all_idle_i(all_idle), .shdn_n_i(shutdown_n_i),
    .idle_done_o(idle_done), .status_o(status_o));

  lpm_power_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .shdn_n_i(shutdown_n_i), .online_i(online_i),
    .activity_i(~all_idle), .idle_done_i(idle_done),
    .pump_on_o(pump_en_o), .drv_on_o(drv_on));

  lpm_io_gate #(.N_RX(N_RX), .N_TX(N_TX), .MON_IDX(MON_IDX)) u_io (
    .rx_line_i(rx_line_i), .rx_disable_i(rx_disable_i), .tx_data_i(tx_data_i),
    .drv_on_i(drv_on), .rx_out_o(rx_out_o), .rx_oe_o(rx_oe_o), .mon_o(mon_o),
    .tx_out_o(tx_out_o), .tx_oe_o(tx_oe_o));

  // R1: shutdown clears every power output
  p_shdn_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown_n_i |=> (!pump_en_o && !status_o && tx_oe_o == '0));
  // R7: drivers never come up unless the supply was already on
  p_drv_after_pump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe_o[0]) |-> $past(pump_en_o));
endmodule

// File: tb/line_power_ctrl_test.sv
module line_power_ctrl_test;
  localparam int NRX = 5, NTX = 3, MON = 1;
  localparam int SB = 40, RISE = 4, FALL = 12, SET = 20;

  typedef enum int {S_PUMP, S_TXOE, S_STAT, S_RXOE, S_RXOUT, S_MON, S_TXOUT} sig_e;
  typedef struct {
    int          due;
    sig_e        sig;
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NRX-1:0] idle = '1;
  logic [NRX-1:0] rxl = 5'b10110;
  logic [NTX-1:0] txd = 3'b101;
  logic online = 1'b0, shdn_n = 1'b1, rxdis = 1'b0;
  logic pump, status, mon;
  logic [NTX-1:0] txoe, txout;
  logic [NRX-1:0] rxout, rxoe;

  int cyc = 0, checks = 0, fails = 0;
  exp_t exp_q[$];

  line_power_ctrl #(
    .N_RX(NRX), .N_TX(NTX), .MON_IDX(MON), .STANDBY_CYC(SB),
    .STS_RISE_CYC(RISE), .STS_FALL_CYC(FALL), .SETTLE_CYC(SET)
  ) uut (
    .clk(clk), .rst_n(rst_n), .line_idle_i(idle), .rx_line_i(rxl), .tx_data_i(txd),
    .online_i(online), .shutdown_n_i(shdn_n), .rx_disable_i(rxdis),
    .pump_en_o(pump), .tx_oe_o(txoe), .tx_out_o(txout), .status_o(status),
    .rx_out_o(rxout), .rx_oe_o(rxoe), .mon_o(mon));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] actual(sig_e s);
    case (s)
      S_PUMP:  return 32'(pump);
      S_TXOE:  return 32'(txoe);
      S_STAT:  return 32'(status);
      S_RXOE:  return 32'(rxoe);
      S_RXOUT: return 32'(rxout);
      S_MON:   return 32'(mon);
      default: return 32'(txout);
    endcase
  endfunction

  // driver side: expected value due d edges after the current drive point
  task automatic expect_at(int d, sig_e s, logic [31:0] v, string tag);
    exp_t e;
    e.due = cyc + d; e.sig = s; e.val = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // monitor: compares due items at the falling edge
  always @(negedge clk) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].due == cyc) begin
        checks++;
        if (actual(exp_q[i].sig) !== exp_q[i].val) begin
          fails++;
          $display("FAIL %s sig=%0d cyc=%0d actual=%h expected=%h", exp_q[i].tag,
                   exp_q[i].sig, cyc, actual(exp_q[i].sig), exp_q[i].val);
        end
        exp_q.delete(i);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(2);
    // R13 reset state
    expect_at(1, S_PUMP, 0, "R13"); expect_at(1, S_TXOE, 0, "R13"); expect_at(1, S_STAT, 0, "R13");
    step(3);
    rst_n = 1'b1;
    // idle lines after reset: stays in standby
    expect_at(6, S_PUMP, 0, "R3");
    step(8);

    // wake by line activity
    idle = 5'b11011;
    expect_at(2, S_PUMP, 0, "R4"); expect_at(3, S_PUMP, 1, "R4");
    expect_at(RISE + 2, S_STAT, 0, "R5"); expect_at(RISE + 3, S_STAT, 1, "R5");
    expect_at(3 + SET - 1, S_TXOE, 0, "R7"); expect_at(3 + SET, S_TXOE, 7, "R7");
    step(3 + SET + 2);

    // combinational data paths
    txd = 3'b011; rxl = 5'b01001;
    expect_at(1, S_TXOUT, 3'b100, "R11"); expect_at(1, S_RXOUT, 5'b10110, "R9");
    expect_at(1, S_MON, 0, "R10"); expect_at(1, S_RXOE, 5'b11111, "R9");
    step(2);
    rxdis = 1'b1; rxl = 5'b00010;
    expect_at(1, S_RXOE, 0, "R9"); expect_at(1, S_MON, 1, "R10"); expect_at(1, S_RXOUT, 5'b11101, "R9");
    step(2);
    rxdis = 1'b0;
    step(1);

    // quiet gap SB-1: no standby
    idle = '1;
    expect_at(FALL + 2, S_STAT, 1, "R6"); expect_at(FALL + 3, S_STAT, 0, "R6");
    expect_at(SB + 3, S_PUMP, 1, "R3");
    step(SB - 1);
    idle = 5'b11110;
    step(RISE + 10);

    // quiet gap SB: standby for one cycle, then rewake
    idle = '1;
    expect_at(SB + 2, S_PUMP, 1, "R3"); expect_at(SB + 3, S_PUMP, 0, "R3");
    expect_at(SB + 3, S_TXOE, 0, "R11"); expect_at(SB + 4, S_PUMP, 1, "R4");
    expect_at(SB + 4 + SET, S_TXOE, 7, "R7");
    step(SB);
    idle = 5'b01111;
    step(SET + 10);

    // quiet gap SB+1
    idle = '1;
    expect_at(SB + 3, S_PUMP, 0, "R3");
    step(SB + 1);
    idle = 5'b11101;
    step(SET + 10);

    // one active line holds the block awake
    idle = 5'b10111;
    expect_at(SB + 12, S_PUMP, 1, "R3");
    step(SB + 14);

    // forced online with all lines idle
    online = 1'b1; idle = '1;
    expect_at(FALL + 3, S_STAT, 0, "R2");
    expect_at(SB + 12, S_PUMP, 1, "R2"); expect_at(SB + 12, S_TXOE, 7, "R2");
    step(SB + 14);
    online = 1'b0;
    expect_at(1, S_PUMP, 0, "R3");
    step(3);

    // online rise wakes from standby
    online = 1'b1;
    expect_at(1, S_PUMP, 1, "R4"); expect_at(SET, S_TXOE, 0, "R7"); expect_at(SET + 1, S_TXOE, 7, "R7");
    step(SET + 3);
    online = 1'b0;
    expect_at(1, S_PUMP, 0, "R3");
    step(3);

    // shutdown during settling cancels the wake
    online = 1'b1;
    step(5);
    shdn_n = 1'b0;
    expect_at(1, S_PUMP, 0, "R8"); expect_at(SET - 4, S_TXOE, 0, "R8"); expect_at(SET + 2, S_TXOE, 0, "R8");
    step(SET + 4);
    shdn_n = 1'b1; online = 1'b0;
    step(3);

    // shutdown while fully active with line traffic
    idle = 5'b11100;
    step(3 + SET + RISE + 5);
    shdn_n = 1'b0; online = 1'b1; rxl = 5'b10101;
    expect_at(1, S_PUMP, 0, "R1"); expect_at(1, S_TXOE, 0, "R1"); expect_at(1, S_STAT, 0, "R1");
    expect_at(1, S_RXOUT, 5'b01010, "R9"); expect_at(1, S_MON, 0, "R10");
    step(4);
    online = 1'b0;
    shdn_n = 1'b1;
    expect_at(1, S_PUMP, 1, "R4"); expect_at(RISE, S_STAT, 0, "R5"); expect_at(RISE + 1, S_STAT, 1, "R5");
    expect_at(SET + 1, S_TXOE, 7, "R7");
    step(SET + 4);

    // online and shutdown tied together, lines idle
    idle = '1;
    online = 1'b0; shdn_n = 1'b0;
    expect_at(1, S_PUMP, 0, "R12");
    step(3);
    online = 1'b1; shdn_n = 1'b1;
    expect_at(1, S_PUMP, 1, "R12"); expect_at(SET + 1, S_TXOE, 7, "R12");
    step(SB + 10);
    online = 1'b0; shdn_n = 1'b0;
    expect_at(1, S_PUMP, 0, "R12"); expect_at(1, S_TXOE, 0, "R12");
    step(4);

    if (exp_q.size() != 0) begin
      fails += exp_q.size();
      $display("FAIL pending checks actual=%0d expected=0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule